// File: doc/BRIEF.md
# Microcode ALU with Carry

A 16-bit arithmetic and logic unit for a small microcode engine. Each cycle it takes two source operands, a 4-bit operation code, two carry control flags and, for the extended shift, a shift field and a width field. It returns a 16-bit result at once. A single flag register holds the carry between instructions.

Reading the carry into an add or subtract and writing the carry back are two separate controls. The engine can therefore chain multi-word arithmetic with or without touching the flag. The extended right shift treats two operands as one 32-bit window and cuts a right-aligned field out of it. Operand fetch, register storage, addressing and decode are left to the surrounding engine.

Top module: `ucode_alu`

## Requirements
- R1: Add (op 0): result = (a + b + cin) mod 2^16, where cin is the stored carry when `use_cy` is 1 and 0 otherwise; `carry_next` is the carry out of bit 15.
- R2: Subtract (op 1): result = (a - b - bin) mod 2^16, where bin is the inverted stored carry when `use_cy` is 1 and 0 otherwise; `carry_next` is 1 when no borrow occurred, i.e. a >= b + bin.
- R3: The stored `carry` resets to 0 and is loaded with `carry_next` on a rising clock edge only when `en`, `set_cy` and an add or subtract opcode are all present; in every other case it holds its value.
- R4: For every opcode other than add and subtract, `carry_next` equals the stored `carry`.
- R5: Arithmetic right shift (op 2) shifts a right by b[3:0] and fills with bit 15 of a.
- R6: Logical right shift (op 6) and left shift (op 7) move a by b[3:0] and fill with zeros.
- R7: Rotate left (op 9) and rotate right (op 10) rotate a by b[3:0] bit positions.
- R8: OR (op 3), AND (op 4) and XOR (op 5) are bitwise on a and b.
- R9: Clear-bits (op 11) gives a AND NOT b.
- R10: Extended shift (op 8) forms the window {b, a}, with b in the upper half, shifts it right by `xshift` and keeps the low `xwidth`+1 bits, which gives a field 1 to 16 bits wide.
- R11: Opcodes 12 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Instruction valid; enables the carry update |
| op | input | 4 | Operation code |
| use_cy | input | 1 | Consume stored carry (add) or inverted carry as borrow (subtract) |
| set_cy | input | 1 | Write the carry flag from this add or subtract |
| a | input | 16 | First operand |
| b | input | 16 | Second operand; low 4 bits give the shift or rotate amount |
| xshift | input | 4 | Extended shift amount |
| xwidth | input | 4 | Extended field width minus one |
| result | output | 16 | Result |
| carry_next | output | 1 | Carry the current instruction would store |
| carry | output | 1 | Stored carry flag |

## Verification
The bench targets wrap points: all-ones plus one with carry-in, zero minus one with borrow-in, shift and rotate amounts of 0 and 15, and extended fields that reach across the two-register seam or span the full 16 bits. A design that inverted the borrow sense, or ignored `use_cy`, gives results that are off by one in chained arithmetic. Driving `set_cy` with `en` low, and with logic opcodes, shows whether a design writes the flag when it should hold it. An off-by-one in the width field loses or adds one top bit in the extracted field.

// File: rtl/ucode_alu.sv
module ucode_alu #(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    op,
  input  logic          use_cy,
  input  logic          set_cy,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] xshift,
  input  logic [SW-1:0] xwidth,
  output logic [W-1:0]  result,
  output logic          carry_next,
  output logic          carry
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_SRA = 4'd2, OP_OR  = 4'd3,
                         OP_AND = 4'd4, OP_XOR = 4'd5, OP_SHR = 4'd6, OP_SHL = 4'd7,
                         OP_XSR = 4'd8, OP_ROL = 4'd9, OP_ROR = 4'd10, OP_CLR = 4'd11;

  logic [SW-1:0]  sh;
  logic [SW:0]    back;
  logic [W:0]     sum, dif;
  logic [2*W-1:0] win;
  logic [W-1:0]   msk;
  logic           arith;

  assign sh    = b[SW-1:0];
  assign back  = (SW+1)'(W) - {1'b0, sh};
  assign sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, use_cy & carry};
  assign dif   = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, use_cy & ~carry};
  assign win   = {b, a} >> xshift;
  assign msk   = {W{1'b1}} >> (SW'(W-1) - xwidth);
  assign arith = (op == OP_ADD) || (op == OP_SUB);

  always_comb begin
    carry_next = carry;
    case (op)
      OP_ADD: begin result = sum[W-1:0]; carry_next = sum[W]; end
      OP_SUB: begin result = dif[W-1:0]; carry_next = ~dif[W]; end
      OP_SRA: result = W'($signed(a) >>> sh);
      OP_OR:  result = a | b;
      OP_AND: result = a & b;
      OP_XOR: result = a ^ b;
      OP_SHR: result = a >> sh;
      OP_SHL: result = a << sh;
      OP_XSR: result = win[W-1:0] & msk;
      OP_ROL: result = (a << sh) | (a >> back);
      OP_ROR: result = (a >> sh) | (a << back);
      OP_CLR: result = a & ~b;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     carry <= 1'b0;
    else if (en && set_cy && arith) carry <= carry_next;

  // R3
  carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set_cy && arith) |=> carry == $past(carry_next));
  // R3
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && set_cy && arith) |=> $stable(carry));
  // R4
  carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arith |-> carry_next == carry);
  // R7
  rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL || op == OP_ROR) |-> $countones(result) == $countones(a));
  // R9
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |-> (result & b) == '0);
  // R10
  xsr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XSR) |-> (result & ~msk) == '0);
endmodule

// File: tb/test_ucode_alu.sv
`timescale 1ns/1ps
module test_ucode_alu;
  logic clk = 0, rst_n = 0, en = 0, use_cy = 0, set_cy = 0;
  logic [3:0] op = 0, xshift = 0, xwidth = 0;
  logic [15:0] a = 0, b = 0;
  logic [15:0] result;
  logic carry_next, carry;
  int checks = 0, errors = 0;
  bit mcy = 0;

  always #5 clk = ~clk;

  ucode_alu i_ucode_alu (.clk, .rst_n, .en, .op, .use_cy, .set_cy, .a, .b,
                         .xshift, .xwidth, .result, .carry_next, .carry);

  function automatic string tag(int o);
    case (o)
      0: return "R1";  1: return "R2";  2: return "R5";  3, 4, 5: return "R8";
      6, 7: return "R6";  8: return "R10";  9, 10: return "R7";  11: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic expect1(string r, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (op %0d a %h b %h)", r, act, exp, op, a, b);
    end
  endtask

  task automatic run(int o, bit e, bit uc, bit sc, int va, int vb, int xs, int xw);
    int r, s, t;
    bit c;
    longint w;
    @(negedge clk);
    op = 4'(o); en = e; use_cy = uc; set_cy = sc; a = 16'(va); b = 16'(vb);
    xshift = 4'(xs); xwidth = 4'(xw);
    #1;
    s = vb & 15; c = mcy; r = 0;
    case (o)
      0: begin t = va + vb + ((uc && mcy) ? 1 : 0); r = t & 'hFFFF; c = t > 'hFFFF; end
      1: begin t = va - vb - ((uc && !mcy) ? 1 : 0); r = t & 'hFFFF; c = t >= 0; end
      2: begin r = va; repeat (s) r = (r >> 1) | (r & 'h8000); end
      3: r = va | vb;
      4: r = va & vb;
      5: r = va ^ vb;
      6: r = va / (1 << s);
      7: r = (va * (1 << s)) & 'hFFFF;
      8: begin w = longint'(vb) * 65536 + va; w = w / (64'd1 << xs); r = int'(w % (64'd1 << (xw + 1))); end
      9: begin r = va; repeat (s) r = ((r << 1) | (r >> 15)) & 'hFFFF; end
      10: begin r = va; repeat (s) r = (r >> 1) | ((r & 1) << 15); end
      11: r = va & ~vb & 'hFFFF;
      default: r = 0;
    endcase
    expect1(tag(o), result, r);
    expect1((o < 2) ? tag(o) : "R4", carry_next, c);
    expect1("R3", carry, mcy);
    @(posedge clk);
    if (e && sc && o < 2) mcy = c;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 expect1("R3", carry, 0);
    rst_n = 1;
    run(0, 1, 0, 1, 'hFFFF, 1, 0, 0);      // R1 wrap sets carry
    run(0, 1, 1, 0, 'h0001, 'h0002, 0, 0); // R1 add with carry-in, no write
    run(0, 1, 1, 1, 'hFFFF, 0, 0, 0);      // R1 carry chain
    run(1, 1, 0, 1, 0, 1, 0, 0);           // R2 borrow, carry 0
    run(1, 1, 1, 1, 5, 2, 0, 0);           // R2 borrow-in consumed
    run(1, 0, 0, 1, 9, 3, 0, 0);           // R3 en low, no write
    run(3, 1, 0, 1, 1, 2, 0, 0);           // R3/R4 logic op keeps flag
    run(2, 1, 0, 0, 'h8000, 15, 0, 0);     // R5
    run(2, 1, 0, 0, 'h7FF0, 4, 0, 0);      // R5 positive
    run(6, 1, 0, 0, 'h8001, 'hFFF0, 0, 0); // R6 amount 0 from low bits
    run(7, 1, 0, 0, 'h0003, 15, 0, 0);     // R6
    run(9, 1, 0, 0, 'h8001, 1, 0, 0);      // R7
    run(10, 1, 0, 0, 'h8001, 15, 0, 0);    // R7
    run(11, 1, 0, 0, 'hF0F0, 'hFF00, 0, 0);// R9
    run(8, 1, 0, 0, 'h1234, 'hABCD, 12, 7);// R10 across seam
    run(8, 1, 0, 0, 'h1234, 'hABCD, 15, 15);// R10 full width
    run(8, 1, 0, 0, 'h1234, 'hABCD, 0, 0); // R10 one bit
    run(13, 1, 1, 1, 'hFFFF, 'hFFFF, 0, 0);// R11
    for (int i = 0; i < 3000; i++)
      run($urandom_range(15), $urandom_range(3) != 0, $urandom_range(1), $urandom_range(1),
          $urandom_range(16'hFFFF), $urandom_range(16'hFFFF), $urandom_range(15), $urandom_range(15));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule